// File: doc/BRIEF.md
# Dual-Bank Calendar Configuration Register Block

This block is the host-facing register file for a transmit status-calendar engine that keeps two calendar banks. One bank is in service while the other is reprogrammed. A simple memory-mapped slave port with a 4-bit word address and 16-bit data reaches the following:

- identity fields;
- a switch that enables hitless bank changes;
- a resync request;
- a multiplier and a length for each bank;
- a shared indirect address register;
- two data windows into external synchronous calendar RAMs, one per bank.

The engine reports three things back to the block: its 2-bit active-bank select word, its sync flag and its disabled flag. From these the block decides which bank may be written. A write to the bank in service is dropped unless the engine is disabled. This lets software prepare the idle bank without disturbing the frames that are being sent.

The calendar RAMs lie outside the block. The block drives one address bus and one write-data bus to both RAMs, plus a write strobe for each RAM. It takes one read-data bus from each RAM. A read of a RAM window holds waitrequest for one cycle, so that the registered RAM output can be captured and returned.

Top module: `calbank_csr`

## Requirements
- R1: Address 0 is read-only. It returns the BLOCK_ID parameter in bits 15:13 and the ID_CODE parameter in bits 12:0. Writes to it change nothing.
- R2: Address 1 bit 0 is a read/write hitless-switch enable. It drives `cfg_hitless_en`.
- R3: Address 1 bit 1 is a read/write resync request that resets to 1. `cfg_resync` is high whenever this bit or `ext_resync` is high.
- R4: A read of address 1 returns the following bits, with all others zero:
  - bit 3: the active bank, 1 when `eng_calsel` is 2'b10 and 0 otherwise (2'b01 selects bank 0);
  - bit 4: `eng_sync`;
  - bit 5: `eng_disabled`;
  - bit 2: zero.
- R5: Addresses 2 to 6 hold the following registers. Each drives its configuration output and reads back zero-extended from bit 0:
  - address 2: bank-0 multiplier (8 bits);
  - address 3: bank-1 multiplier (8 bits);
  - address 4: bank-0 length (10 bits);
  - address 5: bank-1 length (10 bits);
  - address 6: indirect RAM address (10 bits), driven on `ram_addr` and writable at any time.
- R6: A write to address 7 pulses `ram0_we` in the write cycle, with `ram_wdata` equal to the low 8 data bits. Address 8 does the same on `ram1_we`.
- R7: A read of address 7 or 8 holds `av_waitreq` high for exactly one cycle. It then returns the bank RAM's output for the current indirect address.
- R8: While hitless switching is off, addresses 3, 5 and 8 read as zero and ignore writes, and `ram1_we` never pulses.
- R9: Bank-0 registers (addresses 2, 4 and 7) accept writes only while `eng_disabled` is 1 or bank 1 is active. Bank-1 registers (addresses 3, 5 and 8) accept writes only while `eng_disabled` is 1 or bank 0 is active. Other writes are dropped.
- R10: Addresses 9 to 15 read as zero and ignore writes.
- R11: An accepted read raises `av_rdvalid` with its data in the cycle after acceptance. Reads of addresses other than 7 and 8 never see waitrequest.
- R12: After reset, every read/write field is zero except the resync bit, which is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| av_addr | input | 4 | Word address |
| av_read | input | 1 | Read request |
| av_write | input | 1 | Write request |
| av_wdata | input | 16 | Write data |
| av_rdata | output | 16 | Read data |
| av_rdvalid | output | 1 | Read data valid |
| av_waitreq | output | 1 | Stall for RAM window reads |
| eng_calsel | input | 2 | Active-bank select word from engine |
| eng_sync | input | 1 | Engine sync status |
| eng_disabled | input | 1 | Engine disabled status |
| ext_resync | input | 1 | External resync request |
| cfg_hitless_en | output | 1 | Hitless switch enable |
| cfg_resync | output | 1 | Resync request to engine |
| cfg_mult0 | output | 8 | Bank-0 multiplier |
| cfg_mult1 | output | 8 | Bank-1 multiplier |
| cfg_len0 | output | 10 | Bank-0 length |
| cfg_len1 | output | 10 | Bank-1 length |
| ram_addr | output | 10 | Shared calendar RAM address |
| ram_wdata | output | 8 | Calendar RAM write data |
| ram0_we | output | 1 | Bank-0 RAM write strobe |
| ram1_we | output | 1 | Bank-1 RAM write strobe |
| ram0_rdata | input | 8 | Bank-0 RAM read data |
| ram1_rdata | input | 8 | Bank-1 RAM read data |

## Verification
The bench keeps the default field widths and a full 1024-entry RAM span, so the indirect address reaches its top entry. It overrides ID_CODE to 13'h1ABC and BLOCK_ID to 3'd5. These non-default values show that the identity word is assembled from parameters and that both fields land in their own bit ranges. The engine status inputs are moved through every pairing of disabled flag and active bank, with hitless switching both on and off. This brings each bank-protection case and each reserved-bank case within reach.

// File: rtl/calbank_csr.sv
module calbank_csr #(
  parameter logic [12:0] ID_CODE  = 13'h0A51,
  parameter logic [2:0]  BLOCK_ID = 3'd1,
  parameter int MULT_W = 8,
  parameter int LEN_W  = 10,
  parameter int RAM_AW = 10,
  parameter int RAM_DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        av_addr,
  input  logic              av_read,
  input  logic              av_write,
  input  logic [15:0]       av_wdata,
  output logic [15:0]       av_rdata,
  output logic              av_rdvalid,
  output logic              av_waitreq,
  input  logic [1:0]        eng_calsel,
  input  logic              eng_sync,
  input  logic              eng_disabled,
  input  logic              ext_resync,
  output logic              cfg_hitless_en,
  output logic              cfg_resync,
  output logic [MULT_W-1:0] cfg_mult0,
  output logic [MULT_W-1:0] cfg_mult1,
  output logic [LEN_W-1:0]  cfg_len0,
  output logic [LEN_W-1:0]  cfg_len1,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [RAM_DW-1:0] ram_wdata,
  output logic              ram0_we,
  output logic              ram1_we,
  input  logic [RAM_DW-1:0] ram0_rdata,
  input  logic [RAM_DW-1:0] ram1_rdata
);

  logic        hitless_q, resync_q, stall_q;
  logic        act1, bank0_ok, bank1_ok, ram_rd, rd_acc, wr_acc;
  logic [15:0] rd_mux;

  assign act1       = (eng_calsel == 2'b10);
  assign bank0_ok   = eng_disabled | act1;
  assign bank1_ok   = hitless_q & (eng_disabled | ~act1);
  assign ram_rd     = av_read & ((av_addr == 4'd7) | (av_addr == 4'd8));
  assign av_waitreq = ram_rd & ~stall_q;
  assign rd_acc     = av_read & ~av_waitreq;
  assign wr_acc     = av_write & ~av_read;

  assign cfg_hitless_en = hitless_q;
  assign cfg_resync     = resync_q | ext_resync;
  assign ram_wdata      = av_wdata[RAM_DW-1:0];
  assign ram0_we        = wr_acc & (av_addr == 4'd7) & bank0_ok;
  assign ram1_we        = wr_acc & (av_addr == 4'd8) & bank1_ok;

  always_comb begin
    rd_mux = '0;
    case (av_addr)
      4'd0: rd_mux = {BLOCK_ID, ID_CODE};
      4'd1: rd_mux = {10'd0, eng_disabled, eng_sync, act1, 1'b0, resync_q, hitless_q};
      4'd2: rd_mux = 16'(cfg_mult0);
      4'd3: rd_mux = hitless_q ? 16'(cfg_mult1) : 16'd0;
      4'd4: rd_mux = 16'(cfg_len0);
      4'd5: rd_mux = hitless_q ? 16'(cfg_len1) : 16'd0;
      4'd6: rd_mux = 16'(ram_addr);
      4'd7: rd_mux = 16'(ram0_rdata);
      4'd8: rd_mux = hitless_q ? 16'(ram1_rdata) : 16'd0;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hitless_q  <= 1'b0;
      resync_q   <= 1'b1;
      stall_q    <= 1'b0;
      cfg_mult0  <= '0;
      cfg_mult1  <= '0;
      cfg_len0   <= '0;
      cfg_len1   <= '0;
      ram_addr   <= '0;
      av_rdata   <= '0;
      av_rdvalid <= 1'b0;
    end else begin
      stall_q    <= ram_rd & ~stall_q;
      av_rdvalid <= rd_acc;
      if (rd_acc) av_rdata <= rd_mux;
      if (wr_acc) begin
        case (av_addr)
          4'd1: begin
            hitless_q <= av_wdata[0];
            resync_q  <= av_wdata[1];
          end
          4'd2: if (bank0_ok) cfg_mult0 <= av_wdata[MULT_W-1:0];
          4'd3: if (bank1_ok) cfg_mult1 <= av_wdata[MULT_W-1:0];
          4'd4: if (bank0_ok) cfg_len0  <= av_wdata[LEN_W-1:0];
          4'd5: if (bank1_ok) cfg_len1  <= av_wdata[LEN_W-1:0];
          4'd6: ram_addr <= av_wdata[RAM_AW-1:0];
          default: ;
        endcase
      end
    end
  end

endmodule

module calbank_csr_chk (
  input logic       clk,
  input logic       rst,
  input logic       av_read,
  input logic       av_waitreq,
  input logic       av_rdvalid,
  input logic [1:0] eng_calsel,
  input logic       eng_disabled,
  input logic       ext_resync,
  input logic       cfg_hitless_en,
  input logic       cfg_resync,
  input logic       ram0_we,
  input logic       ram1_we
);
  // R9
  bank0_guard_chk: assert property (@(posedge clk) disable iff (rst)
    ram0_we |-> (eng_disabled || eng_calsel == 2'b10));
  // R9
  bank1_guard_chk: assert property (@(posedge clk) disable iff (rst)
    ram1_we |-> (eng_disabled || eng_calsel != 2'b10));
  // R8
  bank1_hitless_chk: assert property (@(posedge clk) disable iff (rst)
    ram1_we |-> cfg_hitless_en);
  // R7
  stall_once_chk: assert property (@(posedge clk) disable iff (rst)
    av_waitreq |=> !av_waitreq);
  // R11
  rdvalid_next_chk: assert property (@(posedge clk) disable iff (rst)
    (av_read && !av_waitreq) |=> av_rdvalid);
  // R3
  resync_or_chk: assert property (@(posedge clk) disable iff (rst)
    ext_resync |-> cfg_resync);
endmodule

bind calbank_csr calbank_csr_chk u_chk (
  .clk(clk), .rst(rst), .av_read(av_read), .av_waitreq(av_waitreq),
  .av_rdvalid(av_rdvalid), .eng_calsel(eng_calsel), .eng_disabled(eng_disabled),
  .ext_resync(ext_resync), .cfg_hitless_en(cfg_hitless_en), .cfg_resync(cfg_resync),
  .ram0_we(ram0_we), .ram1_we(ram1_we)
);

// File: tb/calbank_csr_tb.sv
`timescale 1ns/1ps
module calbank_csr_tb;
  localparam logic [12:0] IDC = 13'h1ABC;
  localparam logic [2:0]  BID = 3'd5;

  logic clk = 0, rst = 1;
  logic [3:0] av_addr = 0;
  logic av_read = 0, av_write = 0;
  logic [15:0] av_wdata = 0;
  logic [15:0] av_rdata;
  logic av_rdvalid, av_waitreq;
  logic [1:0] eng_calsel = 2'b01;
  logic eng_sync = 0, eng_disabled = 0, ext_resync = 0;
  logic cfg_hitless_en, cfg_resync;
  logic [7:0] cfg_mult0, cfg_mult1;
  logic [9:0] cfg_len0, cfg_len1, ram_addr;
  logic [7:0] ram_wdata, ram0_rdata, ram1_rdata;
  logic ram0_we, ram1_we;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  calbank_csr #(.ID_CODE(IDC), .BLOCK_ID(BID)) u_dut (.*);

  // calendar RAMs in the environment
  logic [7:0] mem0 [1024];
  logic [7:0] mem1 [1024];
  always @(posedge clk) begin
    if (ram0_we) mem0[ram_addr] <= ram_wdata;
    if (ram1_we) mem1[ram_addr] <= ram_wdata;
    ram0_rdata <= mem0[ram_addr];
    ram1_rdata <= mem1[ram_addr];
  end

  // reference model
  logic [7:0] e_mem0 [1024];
  logic [7:0] e_mem1 [1024];
  logic m_hb, m_rs, m_stall, m_rv;
  logic [7:0] m_m0, m_m1;
  logic [9:0] m_l0, m_l1, m_adr;
  logic [15:0] m_rd;
  string m_tag;

  function automatic logic act1_f(); return eng_calsel == 2'b10; endfunction
  function automatic logic ok0_f(); return eng_disabled || act1_f(); endfunction
  function automatic logic ok1_f(); return m_hb && (eng_disabled || !act1_f()); endfunction
  function automatic logic is_ram_rd(); return av_read && (av_addr == 7 || av_addr == 8); endfunction
  function automatic logic exp_wait(); return is_ram_rd() && !m_stall; endfunction

  function automatic string tag_of(input logic [3:0] a);
    if (a == 0) return "R1";
    if (a == 1) return "R4";
    if (!m_hb && (a == 3 || a == 5 || a == 8)) return "R8";
    if (a >= 2 && a <= 6) return "R5";
    if (a == 7 || a == 8) return "R7";
    return "R10";
  endfunction

  function automatic logic [15:0] exp_read(input logic [3:0] a);
    case (a)
      0: return {BID, IDC};
      1: return {10'd0, eng_disabled, eng_sync, act1_f(), 1'b0, m_rs, m_hb};
      2: return {8'd0, m_m0};
      3: return m_hb ? {8'd0, m_m1} : 16'd0;
      4: return {6'd0, m_l0};
      5: return m_hb ? {6'd0, m_l1} : 16'd0;
      6: return {6'd0, m_adr};
      7: return {8'd0, e_mem0[m_adr]};
      8: return m_hb ? {8'd0, e_mem1[m_adr]} : 16'd0;
      default: return 16'd0;
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem0[i] = 0; mem1[i] = 0; e_mem0[i] = 0; e_mem1[i] = 0;
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      m_hb <= 0; m_rs <= 1; m_stall <= 0; m_rv <= 0; m_rd <= 0;
      m_m0 <= 0; m_m1 <= 0; m_l0 <= 0; m_l1 <= 0; m_adr <= 0;
    end else begin
      m_stall <= is_ram_rd() && !m_stall;
      m_rv <= av_read && !exp_wait();
      if (av_read && !exp_wait()) begin
        m_rd <= exp_read(av_addr);
        m_tag <= tag_of(av_addr);
      end
      if (av_write && !av_read) begin
        case (av_addr)
          1: begin m_hb <= av_wdata[0]; m_rs <= av_wdata[1]; end
          2: if (ok0_f()) m_m0 <= av_wdata[7:0];
          3: if (ok1_f()) m_m1 <= av_wdata[7:0];
          4: if (ok0_f()) m_l0 <= av_wdata[9:0];
          5: if (ok1_f()) m_l1 <= av_wdata[9:0];
          6: m_adr <= av_wdata[9:0];
          7: if (ok0_f()) e_mem0[m_adr] <= av_wdata[7:0];
          8: if (ok1_f()) e_mem1[m_adr] <= av_wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, sampled after the edge has settled
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      chk(av_rdvalid === m_rv, "R11", av_rdvalid, m_rv);
      if (m_rv) chk(av_rdata === m_rd, m_tag, av_rdata, m_rd);
      chk(av_waitreq === exp_wait(), "R7", av_waitreq, exp_wait());
      chk(cfg_hitless_en === m_hb, "R2", cfg_hitless_en, m_hb);
      chk(cfg_resync === (m_rs | ext_resync), "R3", cfg_resync, m_rs | ext_resync);
      chk(cfg_mult0 === m_m0 && cfg_len0 === m_l0, "R5", {cfg_mult0, cfg_len0}, {m_m0, m_l0});
      chk(cfg_mult1 === m_m1 && cfg_len1 === m_l1, "R9", {cfg_mult1, cfg_len1}, {m_m1, m_l1});
      chk(ram_addr === m_adr, "R5", ram_addr, m_adr);
      chk(ram0_we === (av_write && !av_read && av_addr == 7 && ok0_f()), "R6", ram0_we,
          av_write && !av_read && av_addr == 7 && ok0_f());
      chk(ram1_we === (av_write && !av_read && av_addr == 8 && ok1_f()), "R8", ram1_we,
          av_write && !av_read && av_addr == 8 && ok1_f());
      if (ram0_we || ram1_we) chk(ram_wdata === av_wdata[7:0], "R6", ram_wdata, av_wdata[7:0]);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); av_addr = a; av_wdata = d; av_write = 1;
    @(negedge clk); av_write = 0;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk); av_addr = a; av_read = 1; #1;
    while (av_waitreq) begin @(negedge clk); #1; end
    @(negedge clk); av_read = 0;
  endtask

  task automatic rd_exp(input logic [3:0] a, input logic [15:0] e, input string tag);
    rd(a);
    #1 chk(av_rdata === e, tag, av_rdata, e);
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R12 reset state
    rd_exp(1, 16'h0002, "R12");
    rd_exp(2, 16'h0000, "R12");
    rd_exp(6, 16'h0000, "R12");
    rd_exp(0, {BID, IDC}, "R1");
    wr(0, 16'h0000);
    rd_exp(0, {BID, IDC}, "R1");
    // bank 0 active, engine running: bank-0 writes dropped (R9)
    wr(2, 16'h0055);
    rd_exp(2, 16'h0000, "R9");
    // hitless off: bank 1 reserved (R8)
    eng_disabled = 1;
    wr(3, 16'h00AA);
    wr(5, 16'h0123);
    rd_exp(3, 16'h0000, "R8");
    rd_exp(5, 16'h0000, "R8");
    wr(8, 16'h00EE);
    rd_exp(8, 16'h0000, "R8");
    // disabled: bank 0 writable
    wr(2, 16'hFF33);
    wr(4, 16'hFFFF);
    rd_exp(4, 16'h03FF, "R5");
    wr(6, 16'h03FF);
    wr(7, 16'h005A);
    rd_exp(7, 16'h005A, "R7");
    wr(6, 16'h0010);
    wr(7, 16'h0011);
    // enable hitless, clear resync (R2/R3)
    wr(1, 16'h0001);
    ext_resync = 1; @(negedge clk); ext_resync = 0;
    wr(3, 16'h0077);
    wr(5, 16'h0200);
    wr(8, 16'h00C4);
    rd_exp(8, 16'h00C4, "R7");
    rd_exp(7, 16'h0011, "R7");
    wr(6, 16'h03FF);
    rd_exp(7, 16'h005A, "R6");
    rd_exp(8, 16'h0000, "R6");
    // running, bank 0 active: only bank 1 writable
    eng_disabled = 0; eng_sync = 1; eng_calsel = 2'b01;
    rd_exp(1, 16'h0011, "R4");
    wr(2, 16'h0001); wr(7, 16'h0099); wr(3, 16'h0042); wr(8, 16'h0066);
    rd_exp(2, 16'h0033, "R9");
    rd_exp(3, 16'h0042, "R9");
    rd_exp(7, 16'h005A, "R9");
    rd_exp(8, 16'h0066, "R9");
    // bank 1 active: only bank 0 writable
    eng_calsel = 2'b10;
    rd_exp(1, 16'h0019, "R4");
    wr(3, 16'h0001); wr(8, 16'h0001); wr(2, 16'h0044); wr(4, 16'h0155);
    rd_exp(3, 16'h0042, "R9");
    rd_exp(8, 16'h0066, "R9");
    rd_exp(2, 16'h0044, "R9");
    eng_disabled = 1; eng_sync = 0;
    rd_exp(1, 16'h0029, "R4");
    // reserved addresses
    for (int a = 9; a < 16; a++) begin
      wr(4'(a), 16'hFFFF);
      rd_exp(4'(a), 16'h0000, "R10");
    end
    // hitless off again hides bank 1
    wr(1, 16'h0002);
    rd_exp(3, 16'h0000, "R8");
    rd_exp(8, 16'h0000, "R8");
    wr(8, 16'h0012);
    wr(1, 16'h0001);
    rd_exp(8, 16'h0066, "R8");
    rd_exp(6, 16'h03FF, "R5");
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule